// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block is the sending half of the device end of a PS/2 link. Device logic hands it a chunk of one to `CHUNK_BYTES` bytes, such as a multi-byte scan code or a mouse movement packet. The block sends each byte as an 11-bit serial frame. It generates the link clock itself from a parameterised divider and drives both lines open-drain: each output either pulls its line low or releases it.

The host can hold the clock line low at any time to inhibit the link. If that happens while a frame is in flight and before its eleventh pulse, the block stops sending at once. Once the bus is quiet again, it restarts the whole chunk from its first byte. An inhibit that comes before a frame's first pulse, or after the falling edge of its last pulse, causes no resend. A one-chunk pending slot lets the device logic hand over a new chunk while the link is inhibited or busy.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset both line drivers are released, `busy_o` is 0 and `push_ready_o` is 1. Whenever `busy_o` is 0, both line drivers are released.
- R2: Each byte goes out as 11 clock pulses. The data line carries, in this order: a 0 start bit, the eight data bits least significant first, a parity bit that makes the count of ones across data and parity odd, and a 1 stop bit.
- R3: The data driver changes only while the clock line is low. Each clock-low phase and each clock-high phase lasts `HALF_DIV` system cycles.
- R4: `push_cnt_i` holds the byte count minus one. Byte k of a chunk sits in `push_data_i[8k+7:8k]`, and the bytes are sent in order starting at byte 0.
- R5: A frame starts only after both synchronised lines have been high for `IDLE_CYC` consecutive cycles. After the last line is released, the first clock pulse begins `IDLE_CYC`+2 cycles later (two of those cycles are synchroniser delay).
- R6: If the clock line is held low during pulses 1 to 10 of a frame, the block aborts. Both drivers are released no more than 4 cycles after the line goes low.
- R7: After an abort, the whole chunk is sent again, starting from byte 0, once the bus is quiet again.
- R8: While the host holds the clock low before a frame begins, the block drives no clock pulse. An inhibit before the first falling edge, or after the falling edge of the 11th pulse, causes no resend: the interrupted frame finishes and is sent only once.
- R9: The block holds one pending chunk while another chunk is active or the link is inhibited. `push_ready_o` is 0 while that slot is full, and a push made while `push_ready_o` is 0 is ignored.
- R10: `busy_o` is 1 from the time a chunk becomes active until the high phase of that chunk's final stop bit has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Offer a chunk |
| push_cnt_i | input | CNT_W | Byte count of the chunk minus one |
| push_data_i | input | 8*CHUNK_BYTES | Chunk bytes, byte 0 in the low bits |
| push_ready_o | output | 1 | Pending slot is empty |
| ps2_clk_i | input | 1 | Clock line level as read back |
| ps2_dat_i | input | 1 | Data line level as read back |
| ps2_clk_lo_o | output | 1 | 1 pulls the clock line low |
| ps2_dat_lo_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | A chunk is being sent |

## Verification
A wrong frame bit or a wrong bit count shows up on the data line within one frame, about 22·`HALF_DIV` cycles. The host-side scoreboard then reports a bad start, parity or stop bit, or a byte that does not match. A byte index left stale after an abort shows up on the first resent frame as the wrong byte, so a missed resend or a partial resend fails the byte comparison within one frame time after the bus is released. A quiet-time or guard counter that is off by one changes when the first pulse starts or when the drivers are released, by a cycle or more, and the cycle-exact checks catch this.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int LAST_BIT   = FRAME_BITS - 1;
    // cycles after releasing the clock before the read-back line is trusted
    localparam int SYNC_GUARD = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_QUIET,
        TX_LOW,
        TX_HIGH
    } tx_state_e;

    // frame as sent, index 0 first: start, data LSB..MSB, odd parity, stop
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
        return {1'b1, ~^b, b, 1'b0};
    endfunction

endpackage

// File: rtl/ps2tx_line_sync.sv
module ps2tx_line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= raw_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/ps2tx_chunk_buf.sv
module ps2tx_chunk_buf #(
    parameter int CHUNK_BYTES = 4,
    parameter int CNT_W       = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_valid_i,
    input  logic [CNT_W-1:0]         push_cnt_i,
    input  logic [CHUNK_BYTES*8-1:0] push_data_i,
    output logic                     push_ready_o,
    input  logic                     done_i,
    output logic                     act_valid_o,
    output logic [CNT_W-1:0]         act_cnt_o,
    output logic [CHUNK_BYTES*8-1:0] act_data_o
);

    localparam int DW = CHUNK_BYTES * 8;

    typedef struct packed {
        logic             pend_v;
        logic [CNT_W-1:0] pend_cnt;
        logic [DW-1:0]    pend_data;
        logic             act_v;
        logic [CNT_W-1:0] act_cnt;
        logic [DW-1:0]    act_data;
    } slots_t;

    slots_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i) s_d.act_v = 1'b0;
        if ((!s_q.act_v || done_i) && s_q.pend_v) begin
            s_d.act_v    = 1'b1;
            s_d.act_cnt  = s_q.pend_cnt;
            s_d.act_data = s_q.pend_data;
            s_d.pend_v   = 1'b0;
        end
        if (push_valid_i && !s_q.pend_v) begin
            s_d.pend_v    = 1'b1;
            s_d.pend_cnt  = push_cnt_i;
            s_d.pend_data = push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push_ready_o = !s_q.pend_v;
    assign act_valid_o  = s_q.act_v;
    assign act_cnt_o    = s_q.act_cnt;
    assign act_data_o   = s_q.act_data;

endmodule

// File: rtl/ps2tx_framer.sv
module ps2tx_framer
    import ps2tx_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int HALF_DIV = 8,
    parameter int IDLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_s_i,
    input  logic             dat_s_i,
    input  logic             have_i,
    input  logic [CNT_W-1:0] last_idx_i,
    input  logic [7:0]       byte_i,
    output logic [CNT_W-1:0] byte_idx_o,
    output logic             done_o,
    output logic             clk_lo_o,
    output logic             dat_lo_o
);

    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int QC_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;

    typedef struct packed {
        tx_state_e             st;
        logic [HC_W-1:0]       half;
        logic [3:0]            bit_idx;
        logic [CNT_W-1:0]      byte_idx;
        logic [QC_W-1:0]       quiet;
        logic [FRAME_BITS-1:0] frame;
        logic                  clk_lo;
        logic                  dat_lo;
    } fr_t;

    fr_t f_d, f_q;
    logic done_d;
    logic [3:0] nxt_bit;
    logic [FRAME_BITS-1:0] fresh;

    assign nxt_bit = f_q.bit_idx + 4'd1;
    assign fresh   = build_frame(byte_i);

    always_comb begin
        f_d    = f_q;
        done_d = 1'b0;
        unique case (f_q.st)
            TX_IDLE: begin
                if (have_i) begin
                    f_d.st       = TX_QUIET;
                    f_d.quiet    = '0;
                    f_d.byte_idx = '0;
                end
            end
            TX_QUIET: begin
                if (clk_s_i && dat_s_i) begin
                    if (f_q.quiet == QC_W'(IDLE_CYC - 1)) begin
                        f_d.st      = TX_LOW;
                        f_d.half    = '0;
                        f_d.bit_idx = '0;
                        f_d.frame   = fresh;
                        f_d.clk_lo  = 1'b1;
                        f_d.dat_lo  = ~fresh[0];
                    end else begin
                        f_d.quiet = f_q.quiet + QC_W'(1);
                    end
                end else begin
                    f_d.quiet = '0;
                end
            end
            TX_LOW: begin
                if (f_q.half == HC_W'(HALF_DIV - 1)) begin
                    f_d.st     = TX_HIGH;
                    f_d.half   = '0;
                    f_d.clk_lo = 1'b0;
                end else begin
                    f_d.half = f_q.half + HC_W'(1);
                end
            end
            TX_HIGH: begin
                if (f_q.half >= HC_W'(SYNC_GUARD) && !clk_s_i &&
                    f_q.bit_idx != 4'(LAST_BIT)) begin
                    // host inhibit inside the frame: drop everything, restart chunk
                    f_d.st       = TX_QUIET;
                    f_d.quiet    = '0;
                    f_d.byte_idx = '0;
                    f_d.clk_lo   = 1'b0;
                    f_d.dat_lo   = 1'b0;
                end else if (f_q.half == HC_W'(HALF_DIV - 1)) begin
                    f_d.half = '0;
                    if (f_q.bit_idx != 4'(LAST_BIT)) begin
                        f_d.st      = TX_LOW;
                        f_d.bit_idx = nxt_bit;
                        f_d.clk_lo  = 1'b1;
                        f_d.dat_lo  = ~f_q.frame[nxt_bit];
                    end else if (f_q.byte_idx == last_idx_i) begin
                        f_d.st = TX_IDLE;
                        done_d = 1'b1;
                    end else begin
                        f_d.st       = TX_QUIET;
                        f_d.quiet    = '0;
                        f_d.byte_idx = f_q.byte_idx + CNT_W'(1);
                    end
                end else begin
                    f_d.half = f_q.half + HC_W'(1);
                end
            end
            default: f_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= TX_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign byte_idx_o = f_q.byte_idx;
    assign done_o     = done_d;
    assign clk_lo_o   = f_q.clk_lo;
    assign dat_lo_o   = f_q.dat_lo;

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
    parameter int CHUNK_BYTES = 4,
    parameter int HALF_DIV    = 8,
    parameter int IDLE_CYC    = 16,
    localparam int CNT_W      = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1,
    localparam int DW         = CHUNK_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid_i,
    input  logic [CNT_W-1:0] push_cnt_i,
    input  logic [DW-1:0]    push_data_i,
    output logic             push_ready_o,
    input  logic             ps2_clk_i,
    input  logic             ps2_dat_i,
    output logic             ps2_clk_lo_o,
    output logic             ps2_dat_lo_o,
    output logic             busy_o
);

    logic [1:0]       line_s;
    logic             act_v, done;
    logic [CNT_W-1:0] act_cnt, byte_idx;
    logic [DW-1:0]    act_data;
    logic [7:0]       cur_byte;

    ps2tx_line_sync #(.LINES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({ps2_dat_i, ps2_clk_i}),
        .sync_o (line_s)
    );

    ps2tx_chunk_buf #(.CHUNK_BYTES(CHUNK_BYTES), .CNT_W(CNT_W)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid_i (push_valid_i),
        .push_cnt_i   (push_cnt_i),
        .push_data_i  (push_data_i),
        .push_ready_o (push_ready_o),
        .done_i       (done),
        .act_valid_o  (act_v),
        .act_cnt_o    (act_cnt),
        .act_data_o   (act_data)
    );

    assign cur_byte = act_data[{byte_idx, 3'b000} +: 8];

    ps2tx_framer #(.CNT_W(CNT_W), .HALF_DIV(HALF_DIV), .IDLE_CYC(IDLE_CYC)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_s_i    (line_s[0]),
        .dat_s_i    (line_s[1]),
        .have_i     (act_v),
        .last_idx_i (act_cnt),
        .byte_i     (cur_byte),
        .byte_idx_o (byte_idx),
        .done_o     (done),
        .clk_lo_o   (ps2_clk_lo_o),
        .dat_lo_o   (ps2_dat_lo_o)
    );

    assign busy_o = act_v;

endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
    parameter int HALF_DIV = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ps2_clk_i,
    input logic clk_lo,
    input logic dat_lo,
    input logic busy,
    input logic push_ready
);

    int unsigned lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lo_run <= 0;
        else if (clk_lo) lo_run <= lo_run + 1;
        else             lo_run <= 0;
    end

    assert_released_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!clk_lo && !dat_lo));

    assert_data_moves_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_lo != $past(dat_lo)) |-> !ps2_clk_i);

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_lo) |-> (lo_run == HALF_DIV));

    assert_pending_promoted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && !busy) |=> busy);

    assert_pulse_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lo) |-> busy);

endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps2_clk_i  (ps2_clk_i),
    .clk_lo     (ps2_clk_lo_o),
    .dat_lo     (ps2_dat_lo_o),
    .busy       (busy_o),
    .push_ready (push_ready_o)
);

// File: tb/ps2_dev_tx_tb.sv
`timescale 1ns/1ps
module ps2_dev_tx_tb;

    localparam int CB = 4;
    localparam int HD = 8;
    localparam int IC = 12;

    logic clk = 0, rst_n = 0;
    logic push_valid = 0;
    logic [1:0] push_cnt = '0;
    logic [31:0] push_data = '0;
    logic push_ready, clk_lo, dat_lo, busy;
    logic host_clk_low = 0, host_dat_low = 0;
    logic clk_line, dat_line;

    assign clk_line = !(clk_lo || host_clk_low);
    assign dat_line = !(dat_lo || host_dat_low);

    always #2.5 clk = ~clk;

    ps2_dev_tx #(.CHUNK_BYTES(CB), .HALF_DIV(HD), .IDLE_CYC(IC)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid_i(push_valid), .push_cnt_i(push_cnt),
        .push_data_i(push_data), .push_ready_o(push_ready), .ps2_clk_i(clk_line),
        .ps2_dat_i(dat_line), .ps2_clk_lo_o(clk_lo), .ps2_dat_lo_o(dat_lo), .busy_o(busy)
    );

    int n_checks = 0, n_err = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // host-side monitor / scoreboard
    logic [10:0] bits;
    int mon_cnt = 0, frames_rx = 0, rise_total = 0;
    bit armed = 0;
    logic prev_clk_lo = 0, prev_host = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (host_clk_low && !prev_host && mon_cnt < 10) begin
                mon_cnt = 0;
                armed = 0;
            end
            if (clk_lo && !prev_clk_lo) begin
                rise_total++;
                if (!host_clk_low) armed = 1;
            end
            if (!clk_lo && prev_clk_lo && armed) begin
                armed = 0;
                bits[mon_cnt] = dat_line;
                chk(busy, "R10", "busy during pulse", 32'(busy), 1);
                mon_cnt++;
                if (mon_cnt == 11) begin
                    mon_cnt = 0;
                    frames_rx++;
                    chk(bits[0] == 1'b0, "R2", "start bit", 32'(bits[0]), 0);
                    chk(bits[10] == 1'b1, "R2", "stop bit", 32'(bits[10]), 1);
                    chk(^bits[9:1] == 1'b1, "R2", "odd parity", 32'(bits[9:1]), 32'(bits[9:1]));
                    if (exp_q.size() == 0) begin
                        chk(0, "R4", "unexpected byte", 32'(bits[8:1]), 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(bits[8:1] == e, "R4", "byte order/value", 32'(bits[8:1]), 32'(e));
                    end
                end
            end
            prev_clk_lo = clk_lo;
            prev_host   = host_clk_low;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push_chunk(input int n, input logic [31:0] d, input bit auto_exp);
        tick();
        while (!push_ready) tick();
        push_valid = 1;
        push_cnt   = 2'(n - 1);
        push_data  = d;
        tick();
        push_valid = 0;
        if (auto_exp) for (int i = 0; i < n; i++) exp_q.push_back(d[8*i +: 8]);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || busy) tick();
        repeat (20) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int r0, n, m, f0;
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(!clk_lo, "R1", "clk driver", 32'(clk_lo), 0);
        chk(!dat_lo, "R1", "dat driver", 32'(dat_lo), 0);
        chk(!busy, "R1", "busy", 32'(busy), 0);
        chk(push_ready, "R1", "push_ready", 32'(push_ready), 1);

        // R2/R4 single bytes, several patterns
        push_chunk(1, 32'hA5, 1); drain();
        push_chunk(1, 32'h00, 1); drain();
        push_chunk(1, 32'hFF, 1); drain();
        push_chunk(1, 32'h80, 1); drain();
        // R4 four-byte chunk, byte 0 first
        push_chunk(4, 32'h44332211, 1); drain();

        // R5 quiet time, R3 low-phase width
        host_dat_low = 1;
        push_chunk(1, 32'h96, 1);
        r0 = rise_total;
        repeat (100) tick();
        chk(rise_total == r0, "R5", "no pulse with data held low", 32'(rise_total - r0), 0);
        host_dat_low = 0;
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk); #1;
        end while (!clk_lo);
        chk(n == IC + 2, "R5", "cycles release to first pulse", 32'(n), 32'(IC + 2));
        m = 1;
        forever begin
            tick();
            if (!clk_lo) break;
            m++;
        end
        chk(m == HD, "R3", "clock low phase width", 32'(m), 32'(HD));
        drain();

        // R6/R7 abort inside second frame, whole chunk resent
        f0 = frames_rx;
        exp_q.push_back(8'h3C); exp_q.push_back(8'h3C); exp_q.push_back(8'h00);
        push_chunk(2, 32'h0000003C, 0);
        while (!(frames_rx == f0 + 1 && mon_cnt == 3)) tick();
        host_clk_low = 1;
        repeat (4) tick();
        chk(!clk_lo, "R6", "clk released after abort", 32'(clk_lo), 0);
        chk(!dat_lo, "R6", "dat released after abort", 32'(dat_lo), 0);
        r0 = rise_total;
        repeat (60) tick();
        chk(rise_total == r0, "R6", "no pulse while inhibited", 32'(rise_total - r0), 0);
        host_clk_low = 0;
        drain();
        chk(frames_rx == f0 + 3, "R7", "frames incl. resend", 32'(frames_rx - f0), 3);

        // R8/R9/R10 inhibit before first edge, pending slot, ignored push
        host_clk_low = 1;
        push_chunk(1, 32'h5A, 1);
        push_chunk(1, 32'h77, 1);
        repeat (2) tick();
        chk(!push_ready, "R9", "ready low when slot full", 32'(push_ready), 0);
        push_valid = 1; push_cnt = 2'd0; push_data = 32'h99;
        repeat (3) tick();
        push_valid = 0;
        chk(busy, "R10", "busy while chunk held", 32'(busy), 1);
        r0 = rise_total;
        repeat (200) tick();
        chk(rise_total == r0, "R8", "no pulse before release", 32'(rise_total - r0), 0);
        host_clk_low = 0;
        drain();
        chk(push_ready, "R9", "ready after drain", 32'(push_ready), 1);

        // R8 inhibit after falling edge of the 11th pulse: no resend
        f0 = frames_rx;
        push_chunk(1, 32'hC3, 1);
        while (!(mon_cnt == 10 && clk_lo)) tick();
        host_clk_low = 1;
        repeat (60) tick();
        chk(frames_rx == f0 + 1, "R8", "late inhibit frame completes", 32'(frames_rx - f0), 1);
        chk(!busy, "R10", "busy drops after final stop", 32'(busy), 0);
        host_clk_low = 0;
        repeat (400) tick();
        chk(frames_rx == f0 + 1, "R8", "no resend after late inhibit", 32'(frames_rx - f0), 1);
        chk(exp_q.size() == 0, "R7", "scoreboard empty", 32'(exp_q.size()), 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule